// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a memory-operand request into the 20-bit address that goes out on the memory bus. For each strobed request it forms a 16-bit effective address from the chosen addressing mode, the base and index registers and a displacement. It then picks a segment register, either the mode's default or a requested override, and adds the segment value, shifted left four places, to the effective address.

For string transfers it also produces the next values of the source and destination pointers. Both pointers move by one element in the direction set by the direction flag. An element is one byte or one word. The results are registered one cycle after the request and are flagged with a valid bit. The decoder that feeds the unit and the bus sequencer that consumes its results sit outside it.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `ea`, `pa`, `seg_id`, `si_next` and `di_next` are all 0.
- R2: `out_valid` is 1 on the cycle after each cycle with `in_valid` = 1, and 0 otherwise. When `in_valid` is 0, all other outputs keep their values.
- R3: `pa` equals (segment value × 16 + `ea`) modulo 2^20, where the segment value is the register named by `seg_id`.
- R4: Mode 0 (direct) gives `ea` = `disp`. Mode codes 6 and 7 behave as mode 0.
- R5: Mode 1 (register indirect) gives `ea` = the register chosen by `reg_sel`: 0 BX, 1 BP, 2 SI, 3 DI.
- R6: Mode 2 (based) gives `ea` = base + `disp`, and mode 3 (indexed) gives `ea` = index + `disp`, both modulo 2^16. The base is chosen by `base_sel` (0 BX, 1 BP) and the index by `idx_sel` (0 SI, 1 DI).
- R7: Mode 4 (based indexed) gives `ea` = base + index + `disp` modulo 2^16.
- R8: With no override, the segment is SS when BP serves as the base, which covers mode 1 with `reg_sel` = 1 and modes 2 and 4 with `base_sel` = 1. Every other non-string access uses DS. The codes for `seg_id` and `ovr_seg` are 0 ES, 1 CS, 2 SS and 3 DS.
- R9: Mode 5 (string) with `str_dst` = 0 gives `ea` = SI in segment DS. With `str_dst` = 1 it gives `ea` = DI in segment ES.
- R10: When `ovr_en` = 1, `ovr_seg` replaces the default segment for every access except a string destination, which stays in ES.
- R11: In mode 5 with `str_step` = 1, `si_next` and `di_next` both equal the input pointer plus the step when `dir_down` = 0, or minus the step when `dir_down` = 1, modulo 2^16. The step is 1 when `word_elem` = 0 and 2 when `word_elem` = 1.
- R12: For any other request, `si_next` and `di_next` equal the SI and DI inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| reg_sel | input | 2 | Register for indirect mode |
| base_sel | input | 1 | Base register: 0 BX, 1 BP |
| idx_sel | input | 1 | Index register: 0 SI, 1 DI |
| disp | input | 16 | Displacement |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override request |
| ovr_seg | input | 2 | Override segment code |
| str_dst | input | 1 | String access is the destination |
| str_step | input | 1 | Advance string pointers |
| dir_down | input | 1 | Direction flag: 1 decrements |
| word_elem | input | 1 | String element is a word |
| out_valid | output | 1 | Results valid |
| ea | output | 16 | Effective address |
| pa | output | 20 | Physical address |
| seg_id | output | 2 | Segment code used |
| si_next | output | 16 | Updated SI |
| di_next | output | 16 | Updated DI |

## Verification
Most internal faults show up at the ports on the first valid cycle after a request that uses the faulty path. A wrong register, base or index choice shows as a bad `ea`. A wrong default or override choice shows in `seg_id`, and `pa` goes wrong with it. A carry that is dropped or not wrapped shows only when a sum overflows 16 or 20 bits, so the stimulus includes values near the top of the range. A pointer that steps wrongly shows in `si_next` or `di_next` on the cycle after the string request. A register that loads while `in_valid` is low shows when outputs change during idle cycles.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;
  localparam logic [2:0] AM_DIRECT = 3'd0;
  localparam logic [2:0] AM_INDIR  = 3'd1;
  localparam logic [2:0] AM_BASED  = 3'd2;
  localparam logic [2:0] AM_INDEX  = 3'd3;
  localparam logic [2:0] AM_BIDX   = 3'd4;
  localparam logic [2:0] AM_STRING = 3'd5;

  localparam logic [1:0] SEG_ES = 2'd0;
  localparam logic [1:0] SEG_CS = 2'd1;
  localparam logic [1:0] SEG_SS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;

  localparam logic [1:0] RSEL_BX = 2'd0;
  localparam logic [1:0] RSEL_BP = 2'd1;
  localparam logic [1:0] RSEL_SI = 2'd2;
  localparam logic [1:0] RSEL_DI = 2'd3;
endpackage

// File: rtl/sag_ea_unit.sv
`timescale 1ns/1ps
module sag_ea_unit
  import sag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode,
  input  logic [1:0]   reg_sel,
  input  logic         base_sel,
  input  logic         idx_sel,
  input  logic         str_dst,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] bp,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] ea,
  output logic         bp_is_base
);
  // modular three-term offset sum
  function automatic logic [W-1:0] ofs_sum(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [W-1:0] c);
    return a + b + c;
  endfunction

  logic [W-1:0] base_v, idx_v, ind_v;

  assign base_v = base_sel ? bp : bx;
  assign idx_v  = idx_sel  ? di : si;

  always_comb begin
    case (reg_sel)
      RSEL_BX: ind_v = bx;
      RSEL_BP: ind_v = bp;
      RSEL_SI: ind_v = si;
      default: ind_v = di;
    endcase
  end

  always_comb begin
    ea         = disp;
    bp_is_base = 1'b0;
    case (mode)
      AM_INDIR: begin
        ea         = ind_v;
        bp_is_base = (reg_sel == RSEL_BP);
      end
      AM_BASED: begin
        ea         = ofs_sum(base_v, disp, '0);
        bp_is_base = base_sel;
      end
      AM_INDEX:  ea = ofs_sum(idx_v, disp, '0);
      AM_BIDX: begin
        ea         = ofs_sum(base_v, idx_v, disp);
        bp_is_base = base_sel;
      end
      AM_STRING: ea = str_dst ? di : si;
      default:   ea = disp;
    endcase
  end
endmodule

// File: rtl/sag_seg_pick.sv
`timescale 1ns/1ps
module sag_seg_pick
  import sag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode,
  input  logic         str_dst,
  input  logic         bp_is_base,
  input  logic         ovr_en,
  input  logic [1:0]   ovr_seg,
  input  logic [W-1:0] seg_es,
  input  logic [W-1:0] seg_cs,
  input  logic [W-1:0] seg_ss,
  input  logic [W-1:0] seg_ds,
  output logic [1:0]   seg_id,
  output logic [W-1:0] seg_val,
  output logic         dst_pinned
);
  logic [1:0] dflt_id;

  assign dst_pinned = (mode == AM_STRING) && str_dst;

  always_comb begin
    if (dst_pinned)      dflt_id = SEG_ES;
    else if (bp_is_base) dflt_id = SEG_SS;
    else                 dflt_id = SEG_DS;
  end

  assign seg_id = (ovr_en && !dst_pinned) ? ovr_seg : dflt_id;

  always_comb begin
    case (seg_id)
      SEG_ES:  seg_val = seg_es;
      SEG_CS:  seg_val = seg_cs;
      SEG_SS:  seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end
endmodule

// File: rtl/sag_str_step.sv
`timescale 1ns/1ps
module sag_str_step #(
  parameter int W = 16
) (
  input  logic         step_en,
  input  logic         dir_down,
  input  logic         word_elem,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] si_n,
  output logic [W-1:0] di_n
);
  function automatic logic [W-1:0] ptr_move(input logic [W-1:0] p,
                                            input logic down,
                                            input logic wide);
    logic [W-1:0] d;
    d = wide ? W'(2) : W'(1);
    return down ? (p - d) : (p + d);
  endfunction

  assign si_n = step_en ? ptr_move(si, dir_down, word_elem) : si;
  assign di_n = step_en ? ptr_move(di, dir_down, word_elem) : di;
endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen
  import sag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                mode,
  input  logic [1:0]                reg_sel,
  input  logic                      base_sel,
  input  logic                      idx_sel,
  input  logic [OFS_W-1:0]          disp,
  input  logic [OFS_W-1:0]          bx,
  input  logic [OFS_W-1:0]          bp,
  input  logic [OFS_W-1:0]          si,
  input  logic [OFS_W-1:0]          di,
  input  logic [OFS_W-1:0]          seg_es,
  input  logic [OFS_W-1:0]          seg_cs,
  input  logic [OFS_W-1:0]          seg_ss,
  input  logic [OFS_W-1:0]          seg_ds,
  input  logic                      ovr_en,
  input  logic [1:0]                ovr_seg,
  input  logic                      str_dst,
  input  logic                      str_step,
  input  logic                      dir_down,
  input  logic                      word_elem,
  output logic                      out_valid,
  output logic [OFS_W-1:0]          ea,
  output logic [OFS_W+SEG_SHIFT-1:0] pa,
  output logic [1:0]                seg_id,
  output logic [OFS_W-1:0]          si_next,
  output logic [OFS_W-1:0]          di_next
);
  localparam int PA_W = OFS_W + SEG_SHIFT;

  function automatic logic [PA_W-1:0] phys(input logic [OFS_W-1:0] s,
                                           input logic [OFS_W-1:0] o);
    return {s, {SEG_SHIFT{1'b0}}} + PA_W'(o);
  endfunction

  // named internal events, visible to the checker
  logic [OFS_W-1:0] ea_w, seg_val_w, si_w, di_w;
  logic [PA_W-1:0]  pa_w;
  logic [1:0]       seg_id_w;
  logic             bp_base_w, dst_pin_w, step_w;

  assign step_w = (mode == AM_STRING) && str_step;

  sag_ea_unit #(.W(OFS_W)) u_ea (
    .mode(mode), .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .str_dst(str_dst), .disp(disp), .bx(bx), .bp(bp), .si(si), .di(di),
    .ea(ea_w), .bp_is_base(bp_base_w)
  );

  sag_seg_pick #(.W(OFS_W)) u_seg (
    .mode(mode), .str_dst(str_dst), .bp_is_base(bp_base_w),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_id(seg_id_w), .seg_val(seg_val_w), .dst_pinned(dst_pin_w)
  );

  sag_str_step #(.W(OFS_W)) u_step (
    .step_en(step_w), .dir_down(dir_down), .word_elem(word_elem),
    .si(si), .di(di), .si_n(si_w), .di_n(di_w)
  );

  assign pa_w = phys(seg_val_w, ea_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      pa        <= '0;
      seg_id    <= '0;
      si_next   <= '0;
      di_next   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea      <= ea_w;
        pa      <= pa_w;
        seg_id  <= seg_id_w;
        si_next <= si_w;
        di_next <= di_w;
      end
    end
  end
endmodule

// File: rtl/sag_chk.sv
`timescale 1ns/1ps
module sag_chk
  import sag_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   mode,
  input logic         str_dst,
  input logic         str_step,
  input logic         ovr_en,
  input logic [1:0]   ovr_seg,
  input logic         dir_down,
  input logic         word_elem,
  input logic [W-1:0] disp,
  input logic [W-1:0] si,
  input logic [W-1:0] di,
  input logic         out_valid,
  input logic [W-1:0] ea,
  input logic [P-1:0] pa,
  input logic [1:0]   seg_id,
  input logic [W-1:0] si_next,
  input logic [W-1:0] di_next,
  input logic         dst_pin_w
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !in_valid) |=> ($stable(ea) && $stable(pa) && $stable(seg_id)));

  // R3
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pa[3:0] == ea[3:0]));

  // R4
  direct_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_DIRECT) |=> (ea == $past(disp)));

  // R10
  dst_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_pin_w) |=> (seg_id == SEG_ES));

  // R10
  ovr_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovr_en && !dst_pin_w) |=> (seg_id == $past(ovr_seg)));

  // R11
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_STRING && str_step && !dir_down) |=>
      (si_next - $past(si) == ($past(word_elem) ? W'(2) : W'(1))));

  // R12
  no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(mode == AM_STRING && str_step)) |=>
      (si_next == $past(si) && di_next == $past(di)));
endmodule

bind seg_addr_gen sag_chk #(.W(OFS_W), .P(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .str_dst(str_dst), .str_step(str_step), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
  .dir_down(dir_down), .word_elem(word_elem), .disp(disp), .si(si), .di(di),
  .out_valid(out_valid), .ea(ea), .pa(pa), .seg_id(seg_id),
  .si_next(si_next), .di_next(di_next), .dst_pin_w(dst_pin_w)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  reg_sel = '0;
  logic        base_sel = 1'b0, idx_sel = 1'b0;
  logic [15:0] disp = '0, bx = '0, bp = '0, si = '0, di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic        str_dst = 1'b0, str_step = 1'b0, dir_down = 1'b0, word_elem = 1'b0;
  logic        out_valid;
  logic [15:0] ea, si_next, di_next;
  logic [19:0] pa;
  logic [1:0]  seg_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel), .disp(disp),
    .bx(bx), .bp(bp), .si(si), .di(di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .str_dst(str_dst),
    .str_step(str_step), .dir_down(dir_down), .word_elem(word_elem),
    .out_valid(out_valid), .ea(ea), .pa(pa), .seg_id(seg_id),
    .si_next(si_next), .di_next(di_next)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected effective address, written as a per-mode table lookup
  function automatic logic [15:0] want_ea();
    logic [15:0] b, x, r;
    b = base_sel ? bp : bx;
    x = idx_sel ? di : si;
    r = (reg_sel == 2'd0) ? bx : (reg_sel == 2'd1) ? bp :
        (reg_sel == 2'd2) ? si : di;
    if (mode == 3'd1) return r;
    if (mode == 3'd2) return 16'(b + disp);
    if (mode == 3'd3) return 16'(x + disp);
    if (mode == 3'd4) return 16'(b + x + disp);
    if (mode == 3'd5) return str_dst ? di : si;
    return disp;
  endfunction

  function automatic logic [1:0] want_seg();
    logic uses_bp;
    if (mode == 3'd5 && str_dst) return 2'd0;
    if (ovr_en) return ovr_seg;
    uses_bp = (mode == 3'd1 && reg_sel == 2'd1) ||
              ((mode == 3'd2 || mode == 3'd4) && base_sel);
    return uses_bp ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [19:0] want_pa(input logic [1:0] s, input logic [15:0] e);
    logic [15:0] v;
    logic [20:0] full;
    v = (s == 2'd0) ? seg_es : (s == 2'd1) ? seg_cs : (s == 2'd2) ? seg_ss : seg_ds;
    full = 21'(v) * 21'd16 + 21'(e);
    return full[19:0];
  endfunction

  function automatic logic [15:0] want_ptr(input logic [15:0] p);
    int d;
    if (!(mode == 3'd5 && str_step)) return p;
    d = word_elem ? 2 : 1;
    if (dir_down) d = -d;
    return 16'(int'(p) + d);
  endfunction

  function automatic string mode_req();
    case (mode)
      3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R9";
      default: return "R4";
    endcase
  endfunction

  // drive current inputs as one request, then check one cycle later
  task automatic fire();
    logic [15:0] e_ea, e_si, e_di;
    logic [1:0]  e_sg;
    logic [19:0] e_pa;
    string sreq, preq;
    e_ea = want_ea();
    e_sg = want_seg();
    e_pa = want_pa(e_sg, e_ea);
    e_si = want_ptr(si);
    e_di = want_ptr(di);
    sreq = (mode == 3'd5) ? "R9" : (ovr_en ? "R10" : "R8");
    if (mode == 3'd5 && str_dst && ovr_en) sreq = "R10";
    preq = (mode == 3'd5 && str_step) ? "R11" : "R12";
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk(mode_req(), "ea", 32'(ea), 32'(e_ea));
    chk(sreq, "seg_id", 32'(seg_id), 32'(e_sg));
    chk("R3", "pa", 32'(pa), 32'(e_pa));
    chk(preq, "si_next", 32'(si_next), 32'(e_si));
    chk(preq, "di_next", 32'(di_next), 32'(e_di));
  endtask

  task automatic rand_inputs();
    mode = 3'($urandom_range(0, 7));
    reg_sel = 2'($urandom); base_sel = 1'($urandom); idx_sel = 1'($urandom);
    disp = 16'($urandom); bx = 16'($urandom); bp = 16'($urandom);
    si = 16'($urandom); di = 16'($urandom);
    seg_es = 16'($urandom); seg_cs = 16'($urandom);
    seg_ss = 16'($urandom); seg_ds = 16'($urandom);
    ovr_en = ($urandom_range(0, 3) == 0); ovr_seg = 2'($urandom);
    str_dst = 1'($urandom); str_step = 1'($urandom);
    dir_down = 1'($urandom); word_elem = 1'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] h_ea;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "ea", 32'(ea), 32'd0);
    chk("R1", "pa", 32'(pa), 32'd0);
    chk("R1", "seg_id", 32'(seg_id), 32'd0);
    chk("R1", "si_next", 32'(si_next), 32'd0);
    chk("R1", "di_next", 32'(di_next), 32'd0);

    // directed: indirect via BX, segment 2000h
    seg_ds = 16'h2000; seg_ss = 16'h3000; seg_es = 16'h4000; seg_cs = 16'h1000;
    bx = 16'h0004; bp = 16'h0100; si = 16'h0500; di = 16'h0300;
    mode = 3'd1; reg_sel = 2'd0; fire();
    mode = 3'd1; reg_sel = 2'd1; fire();            // R8 SS via BP
    mode = 3'd4; base_sel = 1'b1; idx_sel = 1'b0; disp = 16'hFFFF;
    bp = 16'hFFFF; si = 16'h0002; fire();           // R7 wrap
    mode = 3'd0; disp = 16'hFFFF; seg_ds = 16'hFFFF; fire(); // R3 20-bit wrap
    // R9 / R11 string source and destination
    mode = 3'd5; str_dst = 1'b0; str_step = 1'b1; dir_down = 1'b0;
    word_elem = 1'b0; si = 16'hFFFF; di = 16'h0301; fire();
    str_dst = 1'b1; dir_down = 1'b1; word_elem = 1'b1;
    si = 16'h0001; di = 16'h0000; fire();
    // R10 override ignored for destination, used for source
    ovr_en = 1'b1; ovr_seg = 2'd1; fire();
    str_dst = 1'b0; fire();
    ovr_en = 1'b0;
    // R12 string without step
    str_step = 1'b0; fire();
    mode = 3'd7; disp = 16'h1234; fire();           // R4 unused code

    // R2 idle cycles hold outputs
    h_ea = ea;
    disp = 16'h5555; mode = 3'd0;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2", "ea held", 32'(ea), 32'(h_ea));

    for (int n = 0; n < 400; n++) begin
      rand_inputs();
      fire();
      if (n % 7 == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule